// File: doc/BRIEF.md
# Table-Driven VGA Timing Generator

This block produces horizontal sync, vertical sync and blanking for a raster display from two free-running counters, a horizontal pixel counter and a vertical line counter. Each counter indexes its own small lookup table. Every word in a table holds three flags: a sync level, a blank flag and a wrap flag. The wrap flag sends the counter back to zero, and a horizontal wrap also advances the line counter. No comparator constants are built into the logic, so the same hardware can run a 640x480 mode, an 800x600 mode or any other mode that fits the counter widths. The host selects the mode by loading the tables.

While the host loads the tables, `run_en` stays low. This holds both counters at zero and parks the outputs in an idle state: syncs low and blank high. Once `run_en` rises, scanning starts from pixel 0 of line 0.

The block also forms the read address into the front half of a double-buffered frame store and gates the 64-colour pixel (2 bits per channel) to black during blanking. A host request to exchange the front and back buffers is held until the next start of vertical blanking and takes effect there.

Top module: `vgatab_top`

## Requirements
- R1: While `rst_n` is low, `hsync_o` and `vsync_o` are 0, `blank_o` is 1, `front_o` is 0, `pix_addr_o` is 0 and `rgb_o` is 0.
- R2: A write with `wr_en` high stores `wr_data` into the horizontal table when `wr_axis` is 0, or into the vertical table when `wr_axis` is 1, at entry `wr_addr`. The word bits are: bit 0 = sync level, bit 1 = blank, bit 2 = wrap. The entry takes effect whenever its counter equals that address.
- R3: One edge after `run_en` is sampled low, both counters are zero, `hsync_o` and `vsync_o` are 0, `blank_o` is 1 and the counter fields of `pix_addr_o` are 0.
- R4: With `run_en` high, after each rising edge `hsync_o` equals the horizontal entry's sync bit and `vsync_o` equals the vertical entry's sync bit, both taken at the counter values present before that edge.
- R5: With `run_en` high, the horizontal counter increments on every edge. After an edge at which its current entry has the wrap bit set, it is 0.
- R6: The vertical counter changes only on edges where the horizontal entry wraps. On such an edge it becomes 0 if its own entry has the wrap bit set, and otherwise increments by one.
- R7: `blank_o` is the OR of the horizontal and vertical blank bits, with the same one-edge timing as R4.
- R8: `rgb_o` equals `pix_i` combinationally while `blank_o` is 0, and is 0 while `blank_o` is 1.
- R9: `pix_addr_o` is {front buffer bit (MSB), vertical counter, horizontal counter (LSBs)}, using the counter values that produced the current sync outputs. Its MSB always equals `front_o`.
- R10: A `swap_req` pulse is held pending. `front_o` toggles on the first edge whose vertical entry has blank set while the previous line's entry had it clear, and at no other time.
- R11: Several requests before one vertical-blank start cause a single toggle. A request sampled on the same edge as a toggle stays pending for the following vertical-blank start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Scan enable; low holds counters at zero |
| wr_en | input | 1 | Table write strobe |
| wr_axis | input | 1 | Table select: 0 horizontal, 1 vertical |
| wr_addr | input | max(HW,VW) | Table entry index |
| wr_data | input | 3 | Table word {wrap, blank, sync} |
| swap_req | input | 1 | Request to exchange front and back buffers |
| pix_i | input | 3*CW | Pixel read from the front buffer |
| hsync_o | output | 1 | Horizontal sync level |
| vsync_o | output | 1 | Vertical sync level |
| blank_o | output | 1 | Blanking interval flag |
| front_o | output | 1 | Buffer currently displayed |
| pix_addr_o | output | 1+VW+HW | Front buffer read address |
| rgb_o | output | 3*CW | Pixel to the DACs, black during blanking |

## Verification
Sync, blank, address and front-buffer outputs are all registered. They show the table entries for the counter values held just before a rising edge, so each result is due one edge after the counters reach that value. The idle state is likewise due one edge after `run_en` is seen low. `rgb_o` follows `pix_i` in the same cycle. The bench therefore advances an arithmetic model of both counters and the swap logic at each rising edge, samples every output at the following falling edge, and checks `rgb_o` after changing `pix_i` within that low phase. It sweeps two full table-defined modes over several frames, together with swap requests placed before, during and across the start of vertical blank.

// File: rtl/vgatab_pkg.sv
package vgatab_pkg;

   // Bit positions of a timing word; the counters and output stage decode them.
   localparam int unsigned F_SYNC  = 0;
   localparam int unsigned F_BLANK = 1;
   localparam int unsigned F_WRAP  = 2;
   localparam int unsigned FW      = 3;

   typedef struct packed {
      logic wrap;
      logic blank;
      logic sync;
   } tword_t;

   typedef enum logic {
      AX_H = 1'b0,
      AX_V = 1'b1
   } axis_e;

endpackage

// File: rtl/vgatab_table.sv
module vgatab_table
   import vgatab_pkg::*;
#(
   parameter int unsigned AW = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  tword_t        wdata,
   input  logic [AW-1:0] raddr,
   output tword_t        rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   tword_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   // Asynchronous read: the entry for the present count is visible in the same cycle.
   assign rdata = mem[raddr];

endmodule

// File: rtl/vgatab_axis_cnt.sv
module vgatab_axis_cnt #(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic         wrap,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= wrap ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/vgatab_swap.sv
module vgatab_swap (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic req,
   input  logic vblank_now,
   output logic front_q,
   output logic front_nxt
);
   logic pend;
   logic vb_q;
   logic fire;

   // Fire only on the first line whose vertical entry is blank.
   assign fire      = run_en & pend & vblank_now & ~vb_q;
   assign front_nxt = front_q ^ fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         front_q <= 1'b0;
         pend    <= 1'b0;
         vb_q    <= 1'b0;
      end else begin
         front_q <= front_nxt;
         pend    <= (pend & ~fire) | req;
         vb_q    <= run_en ? vblank_now : 1'b0;
      end
   end
endmodule

// File: rtl/vgatab_top.sv
module vgatab_top
   import vgatab_pkg::*;
#(
   parameter int unsigned HW = 10,
   parameter int unsigned VW = 10,
   parameter int unsigned CW = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run_en,
   input  logic                      wr_en,
   input  logic                      wr_axis,
   input  logic [((HW>VW)?HW:VW)-1:0] wr_addr,
   input  logic [2:0]                wr_data,
   input  logic                      swap_req,
   input  logic [3*CW-1:0]           pix_i,
   output logic                      hsync_o,
   output logic                      vsync_o,
   output logic                      blank_o,
   output logic                      front_o,
   output logic [VW+HW:0]            pix_addr_o,
   output logic [3*CW-1:0]           rgb_o
);
   localparam int unsigned AW  = (HW > VW) ? HW : VW;
   localparam int unsigned PW  = 3 * CW;
   localparam int unsigned PAW = 1 + VW + HW;

   if (HW < 2 || HW > 12) begin : g_bad_hw
      $error("vgatab_top: HW out of range");
   end
   if (VW < 2 || VW > 12) begin : g_bad_vw
      $error("vgatab_top: VW out of range");
   end
   if (CW < 1 || CW > 8) begin : g_bad_cw
      $error("vgatab_top: CW out of range");
   end
   if (FW != 3) begin : g_bad_fw
      $error("vgatab_top: timing word width mismatch");
   end

   logic [HW-1:0] hcnt;
   logic [VW-1:0] vcnt;
   logic [AW-1:0] rd_addr [2];
   tword_t        word    [2];
   logic          hwrap;
   logic          vwrap;
   logic          front_nxt;

   assign rd_addr[0] = AW'(hcnt);
   assign rd_addr[1] = AW'(vcnt);

   for (genvar g = 0; g < 2; g++) begin : g_tab
      localparam int unsigned TAW = (g == 0) ? HW : VW;
      localparam axis_e       AXS = (g == 0) ? AX_H : AX_V;
      vgatab_table #(.AW(TAW)) u_tab (
         .clk   (clk),
         .we    (wr_en && (wr_axis == AXS)),
         .waddr (wr_addr[TAW-1:0]),
         .wdata (tword_t'(wr_data)),
         .raddr (rd_addr[g][TAW-1:0]),
         .rdata (word[g])
      );
   end

   assign hwrap = word[0].wrap;
   assign vwrap = word[1].wrap;

   vgatab_axis_cnt #(.W(HW)) u_hcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!run_en),
      .step  (run_en),
      .wrap  (hwrap),
      .cnt   (hcnt)
   );

   vgatab_axis_cnt #(.W(VW)) u_vcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!run_en),
      .step  (run_en && hwrap),
      .wrap  (vwrap),
      .cnt   (vcnt)
   );

   vgatab_swap u_swap (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .req        (swap_req),
      .vblank_now (word[1].blank),
      .front_q    (front_o),
      .front_nxt  (front_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync_o    <= 1'b0;
         vsync_o    <= 1'b0;
         blank_o    <= 1'b1;
         pix_addr_o <= '0;
      end else if (!run_en) begin
         hsync_o    <= 1'b0;
         vsync_o    <= 1'b0;
         blank_o    <= 1'b1;
         pix_addr_o <= {front_nxt, {(PAW-1){1'b0}}};
      end else begin
         hsync_o    <= word[0].sync;
         vsync_o    <= word[1].sync;
         blank_o    <= word[0].blank | word[1].blank;
         pix_addr_o <= {front_nxt, vcnt, hcnt};
      end
   end

   assign rgb_o = blank_o ? {PW{1'b0}} : pix_i;

endmodule

// File: rtl/vgatab_chk.sv
module vgatab_chk #(
   parameter int unsigned HW = 10,
   parameter int unsigned VW = 10,
   parameter int unsigned PW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run_en,
   input logic [HW-1:0] hcnt,
   input logic [VW-1:0] vcnt,
   input logic          hwrap,
   input logic          vwrap,
   input logic          hsync_o,
   input logic          vsync_o,
   input logic          blank_o,
   input logic          front_o,
   input logic [PW-1:0] rgb_o
);
   a_r3_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (blank_o && !hsync_o && !vsync_o && hcnt == '0 && vcnt == '0));

   a_r5_h_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !hwrap) |=> hcnt == HW'($past(hcnt) + 1'b1));

   a_r5_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && hwrap) |=> hcnt == '0);

   a_r6_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !hwrap) |=> $stable(vcnt));

   a_r6_v_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && hwrap && vwrap) |=> vcnt == '0);

   a_r8_rgb_dark: assert property (@(posedge clk) disable iff (!rst_n)
      blank_o |-> rgb_o == '0);

   a_r10_swap_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(front_o) |-> blank_o);
endmodule

bind vgatab_top vgatab_chk #(.HW(HW), .VW(VW), .PW(PW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run_en  (run_en),
   .hcnt    (hcnt),
   .vcnt    (vcnt),
   .hwrap   (hwrap),
   .vwrap   (vwrap),
   .hsync_o (hsync_o),
   .vsync_o (vsync_o),
   .blank_o (blank_o),
   .front_o (front_o),
   .rgb_o   (rgb_o)
);

// File: tb/vgatab_top_bench.sv
module vgatab_top_bench;
   localparam int HW = 4;
   localparam int VW = 4;
   localparam int CW = 2;
   localparam int PW = 3 * CW;
   localparam int CLK_PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b0;
   logic          wr_en = 1'b0;
   logic          wr_axis = 1'b0;
   logic [HW-1:0] wr_addr = '0;
   logic [2:0]    wr_data = '0;
   logic          swap_req = 1'b0;
   logic [PW-1:0] pix_i = '0;
   logic          hsync_o, vsync_o, blank_o, front_o;
   logic [VW+HW:0] pix_addr_o;
   logic [PW-1:0] rgb_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // Mode description used both to load the tables and to predict outputs.
   int h_tot, h_act, hs0, hs1, v_tot, v_act, vs0, vs1;
   // Model state.
   int mh, mv, m_front, m_pend, m_vbq, cyc;

   vgatab_top #(.HW(HW), .VW(VW), .CW(CW)) u_vgatab_top (
      .clk, .rst_n, .run_en, .wr_en, .wr_axis, .wr_addr, .wr_data, .swap_req,
      .pix_i, .hsync_o, .vsync_o, .blank_o, .front_o, .pix_addr_o, .rgb_o
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int f_hsync(int h);  return (h >= hs0 && h <= hs1) ? 1 : 0; endfunction
   function automatic int f_vsync(int v);  return (v >= vs0 && v <= vs1) ? 1 : 0; endfunction
   function automatic int f_hblank(int h); return (h >= h_act) ? 1 : 0; endfunction
   function automatic int f_vblank(int v); return (v >= v_act) ? 1 : 0; endfunction

   // R2: bit0 sync, bit1 blank, bit2 wrap; axis 0 horizontal, 1 vertical.
   task automatic write_entry(input bit axis, input int addr, input int sy, input int bl, input int wr);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_axis = axis;
      wr_addr = HW'(addr);
      wr_data = {1'(wr), 1'(bl), 1'(sy)};
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_mode();
      for (int a = 0; a < (1 << HW); a++)
         write_entry(1'b0, a, f_hsync(a), f_hblank(a), (a == h_tot - 1) ? 1 : 0);
      for (int a = 0; a < (1 << VW); a++)
         write_entry(1'b1, a, f_vsync(a), f_vblank(a), (a == v_tot - 1) ? 1 : 0);
   endtask

   function automatic bit req_at(int c);
      return (c == 5) || (c == 20) || (c == 25) || (c >= 95 && c <= 105) || (c == 230);
   endfunction

   // Runs n edges; every output is checked at the falling edge after each rising edge.
   task automatic run_cycles(input int n, input bit run, input string pfx);
      for (int k = 0; k < n; k++) begin
         int eh, ev, exp_hs, exp_vs, exp_bl, exp_addr, fire, vbn, pv;
         bit rq;
         rq = req_at(cyc);
         swap_req = rq;
         run_en = run;
         @(posedge clk);
         if (run) begin
            eh = mh; ev = mv;
            exp_hs = f_hsync(eh); exp_vs = f_vsync(ev);
            exp_bl = f_hblank(eh) | f_vblank(ev);
            vbn = f_vblank(ev);
            fire = (m_pend != 0 && vbn != 0 && m_vbq == 0) ? 1 : 0;
            m_front = m_front ^ fire;
            m_pend = ((m_pend != 0 && fire == 0) || rq) ? 1 : 0;
            m_vbq = vbn;
            if (eh == h_tot - 1) begin
               mh = 0;
               mv = (ev == v_tot - 1) ? 0 : (ev + 1) % (1 << VW);
            end else begin
               mh = (eh + 1) % (1 << HW);
            end
            exp_addr = (m_front << (HW + VW)) | (ev << HW) | eh;
         end else begin
            exp_hs = 0; exp_vs = 0; exp_bl = 1;
            m_pend = (m_pend != 0 || rq) ? 1 : 0;
            m_vbq = 0; mh = 0; mv = 0;
            exp_addr = m_front << (HW + VW);
         end
         cyc++;
         @(negedge clk);
         if (run) begin
            chk({pfx, " R4 hsync"}, int'(hsync_o), exp_hs);
            chk({pfx, " R4 vsync"}, int'(vsync_o), exp_vs);
            chk({pfx, " R7 blank"}, int'(blank_o), exp_bl);
            chk({pfx, " R5 R6 R9 addr"}, int'(pix_addr_o), exp_addr);
         end else begin
            chk({pfx, " R3 idle hsync"}, int'(hsync_o), 0);
            chk({pfx, " R3 idle vsync"}, int'(vsync_o), 0);
            chk({pfx, " R3 idle blank"}, int'(blank_o), 1);
            chk({pfx, " R3 idle addr"}, int'(pix_addr_o), exp_addr);
         end
         chk({pfx, " R10 R11 front"}, int'(front_o), m_front);
         chk({pfx, " R9 addr msb"}, int'(pix_addr_o[HW+VW]), int'(front_o));
         pv = (cyc * 13 + 7) % (1 << PW);
         pix_i = PW'(pv);
         #1;
         chk({pfx, " R8 rgb"}, int'(rgb_o), exp_bl ? 0 : pv);
      end
   endtask

   initial begin
      h_tot = 10; h_act = 6; hs0 = 7; hs1 = 8;
      v_tot = 6;  v_act = 4; vs0 = 5; vs1 = 5;
      mh = 0; mv = 0; m_front = 0; m_pend = 0; m_vbq = 0; cyc = 0;
      pix_i = 6'h2A;
      repeat (3) @(negedge clk);
      chk("R1 reset hsync", int'(hsync_o), 0);
      chk("R1 reset vsync", int'(vsync_o), 0);
      chk("R1 reset blank", int'(blank_o), 1);
      chk("R1 reset front", int'(front_o), 0);
      chk("R1 reset addr", int'(pix_addr_o), 0);
      chk("R1 reset rgb", int'(rgb_o), 0);
      rst_n = 1'b1;
      load_mode();
      run_cycles(4, 1'b0, "modeA");
      run_cycles(200, 1'b1, "modeA");
      // Stop mid-frame, then restart from pixel 0 of line 0.
      run_cycles(3, 1'b0, "stop");
      run_cycles(70, 1'b1, "restart");
      // R2: a different mode purely by rewriting the tables.
      run_en = 1'b0;
      h_tot = 8; h_act = 4; hs0 = 5; hs1 = 6;
      v_tot = 5; v_act = 3; vs0 = 4; vs1 = 4;
      load_mode();
      run_cycles(2, 1'b0, "R2 modeB");
      run_cycles(130, 1'b1, "R2 modeB");
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule